// File: doc/BRIEF.md
# Address Space Privilege Checker

This block sits beside a processor core's memory port and judges every access by an 8-bit address space identifier (ASI) sent with the address, not by the address itself. It holds one privilege bit that selects supervisor or user mode. Each request is either an ordinary instruction fetch or data access, which the block tags with the fixed identifier for the current mode, or an access that names its own identifier, which only supervisor mode may make.

Reset and every trap put the block in supervisor mode. A trap saves the mode in force when it is taken, and a return-from-trap strobe restores it. There is one saved bit, so traps do not nest. The saved bit resets to user, so the first return after reset drops the core into user mode. The outcome of each request appears one clock later on registered outputs: a grant with the identifier to drive on the bus, or a protection fault.

Top module: `asi_guard`

## Requirements
- R1: After synchronous reset, grant and fault are low, bus_asi is 0x00, the mode is supervisor and the saved mode is user.
- R2: Every cycle with req_valid high produces exactly one of grant or fault in the next cycle. A cycle without req_valid produces neither.
- R3: In supervisor mode, a request that names no identifier is tagged 0x09 for a fetch (req_fetch=1) and 0x0B for a data access.
- R4: In user mode, a request that names no identifier is tagged 0x08 for a fetch and 0x0A for a data access.
- R5: A trap strobe saves the current mode and sets supervisor mode. When trap and rett are high in the same cycle, the trap wins.
- R6: A rett strobe without trap sets the mode to the saved value.
- R7: In user mode, a request that names an identifier (req_explicit=1) faults whatever the value.
- R8: In supervisor mode, a request that names any identifier from 0x08 to 0xFF is granted, including the user and application-defined ones, and that value is driven on bus_asi.
- R9: A named identifier in the reserved range 0x00 to 0x07 faults in supervisor mode.
- R10: A request made in the same cycle as a trap or rett is judged under the mode in force before that strobe takes effect.
- R11: bus_asi reads 0x00 in any cycle in which grant is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| req_explicit | input | 1 | Request names its own identifier |
| req_asi | input | 8 | Named identifier, used when req_explicit is high |
| trap | input | 1 | A synchronous or asynchronous trap is taken |
| rett | input | 1 | Return-from-trap strobe |
| bus_asi | output | 8 | Identifier driven with a granted access |
| grant | output | 1 | Access allowed (registered) |
| fault | output | 1 | Protection fault (registered) |

## Verification
The bench infers the mode from the identifier an ordinary fetch receives. It targets the edges of the reserved range (0x07 faults, 0x08 is granted). A design with an off-by-one range check would grant the reserved value or reject the first user identifier. It drives a request in the same cycle as a trap and checks that the request is still judged under user mode. A design that decoded from the next mode would tag it 0x09. It pulses trap and rett together and checks that the block lands in supervisor mode with user saved. A design that let rett win, or that did not save the mode on the trap, would end up in the wrong mode after the next return. It also checks that user mode cannot reach the user identifiers by naming them. A design that checked only the value, not the mode, would grant those requests.

// File: rtl/asi_pkg.sv
package asi_pkg;
  typedef enum logic {
    MODE_USER = 1'b0,
    MODE_SUP  = 1'b1
  } mode_e;
endpackage

// File: rtl/asi_mode_track.sv
module asi_mode_track
  import asi_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  trap,
  input  logic  rett,
  output mode_e mode
);
  mode_e mode_q, saved_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_SUP;
      saved_q <= MODE_USER;
    end else if (trap) begin
      saved_q <= mode_q;
      mode_q  <= MODE_SUP;
    end else if (rett) begin
      mode_q  <= saved_q;
    end
  end

  assign mode = mode_q;

  // R5: any trap lands in supervisor mode
  p_trap_sup_r5: assert property (@(posedge clk) disable iff (rst)
    trap |=> mode_q == MODE_SUP);

  // R5: a trap stores the mode that was in force
  p_trap_save_r5: assert property (@(posedge clk) disable iff (rst)
    trap |=> saved_q == $past(mode_q));

  // R6: return restores the saved mode
  p_rett_restore_r6: assert property (@(posedge clk) disable iff (rst)
    (rett && !trap) |=> mode_q == $past(saved_q));
endmodule

// File: rtl/asi_select.sv
module asi_select
  import asi_pkg::*;
#(
  parameter int ASI_W     = 8,
  parameter int RSV_LIMIT = 8,
  parameter int ID_UINST  = 8'h08,
  parameter int ID_SINST  = 8'h09,
  parameter int ID_UDATA  = 8'h0A,
  parameter int ID_SDATA  = 8'h0B
) (
  input  mode_e            mode,
  input  logic             is_fetch,
  input  logic             explicit_id,
  input  logic [ASI_W-1:0] asi_in,
  output logic [ASI_W-1:0] asi_out,
  output logic             legal
);
  localparam logic [ASI_W-1:0] RSV_TOP = ASI_W'(RSV_LIMIT);

  logic reserved;
  assign reserved = asi_in < RSV_TOP;

  always_comb begin
    asi_out = '0;
    legal   = 1'b0;
    if (explicit_id) begin
      if (mode == MODE_SUP && !reserved) begin
        asi_out = asi_in;
        legal   = 1'b1;
      end
    end else begin
      legal = 1'b1;
      if (mode == MODE_SUP) asi_out = is_fetch ? ASI_W'(ID_SINST) : ASI_W'(ID_SDATA);
      else                  asi_out = is_fetch ? ASI_W'(ID_UINST) : ASI_W'(ID_UDATA);
    end
  end
endmodule

// File: rtl/asi_guard.sv
module asi_guard
  import asi_pkg::*;
#(
  parameter int ASI_W     = 8,
  parameter int RSV_LIMIT = 8,
  parameter int ID_UINST  = 8'h08,
  parameter int ID_SINST  = 8'h09,
  parameter int ID_UDATA  = 8'h0A,
  parameter int ID_SDATA  = 8'h0B
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_fetch,
  input  logic             req_explicit,
  input  logic [ASI_W-1:0] req_asi,
  input  logic             trap,
  input  logic             rett,
  output logic [ASI_W-1:0] bus_asi,
  output logic             grant,
  output logic             fault
);
  localparam logic [ASI_W-1:0] RSV_TOP = ASI_W'(RSV_LIMIT);

  mode_e            mode;
  logic [ASI_W-1:0] sel_asi;
  logic             legal;
  logic [ASI_W-1:0] asi_q;
  logic             grant_q, fault_q;

  asi_mode_track u_mode (
    .clk  (clk),
    .rst  (rst),
    .trap (trap),
    .rett (rett),
    .mode (mode)
  );

  asi_select #(
    .ASI_W(ASI_W), .RSV_LIMIT(RSV_LIMIT),
    .ID_UINST(ID_UINST), .ID_SINST(ID_SINST),
    .ID_UDATA(ID_UDATA), .ID_SDATA(ID_SDATA)
  ) u_sel (
    .mode        (mode),
    .is_fetch    (req_fetch),
    .explicit_id (req_explicit),
    .asi_in      (req_asi),
    .asi_out     (sel_asi),
    .legal       (legal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= 1'b0;
      fault_q <= 1'b0;
      asi_q   <= '0;
    end else begin
      grant_q <= req_valid && legal;
      fault_q <= req_valid && !legal;
      asi_q   <= (req_valid && legal) ? sel_asi : '0;
    end
  end

  assign grant   = grant_q;
  assign fault   = fault_q;
  assign bus_asi = asi_q;

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (grant ^ fault));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!grant && !fault));

  p_user_named_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_explicit && mode == MODE_USER) |=> fault);

  p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_explicit && req_asi < RSV_TOP) |=> fault);

  p_named_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_explicit && mode == MODE_SUP && req_asi >= RSV_TOP)
      |=> (grant && bus_asi == $past(req_asi)));

  p_quiet_bus_r11: assert property (@(posedge clk) disable iff (rst)
    !grant |-> bus_asi == '0);
endmodule

// File: tb/tb_asi_guard.sv
module tb_asi_guard;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid, req_fetch, req_explicit, trap, rett;
  logic [7:0] req_asi;
  logic [7:0] bus_asi;
  logic       grant, fault;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  asi_guard dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_fetch(req_fetch),
    .req_explicit(req_explicit), .req_asi(req_asi), .trap(trap), .rett(rett),
    .bus_asi(bus_asi), .grant(grant), .fault(fault)
  );

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_fetch = 0; req_explicit = 0; req_asi = 0; trap = 0; rett = 0;
  endtask

  // drive one cycle of stimulus at a falling edge, observe at the next one
  task automatic step(input bit v, input bit f, input bit e, input logic [7:0] a,
                      input bit t, input bit r);
    req_valid = v; req_fetch = f; req_explicit = e; req_asi = a; trap = t; rett = r;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic expect_grant(input string req, input logic [7:0] asi);
    chk(req, {grant, fault}, 2'b10);
    chk(req, bus_asi, asi);
  endtask

  task automatic expect_fault(input string req);
    chk(req, {grant, fault}, 2'b01);
    chk({req, " (R11)"}, bus_asi, 0);
  endtask

  task automatic t_reset();
    chk("R1 outputs", {grant, fault, bus_asi}, 0);
    step(1, 1, 0, 0, 0, 0);
    expect_grant("R1 supervisor after reset", 8'h09);
  endtask

  task automatic t_sup_plain();
    step(1, 0, 0, 8'h55, 0, 0);
    expect_grant("R3 supervisor data", 8'h0B);
    step(1, 1, 0, 8'h55, 0, 0);
    expect_grant("R3 supervisor fetch", 8'h09);
  endtask

  task automatic t_idle();
    step(0, 1, 0, 8'h20, 0, 0);
    chk("R2 no request", {grant, fault}, 0);
    chk("R11 idle bus", bus_asi, 0);
  endtask

  task automatic t_sup_named();
    step(1, 0, 1, 8'h08, 0, 0); expect_grant("R8 user inst named", 8'h08);
    step(1, 0, 1, 8'h0A, 0, 0); expect_grant("R8 user data named", 8'h0A);
    step(1, 1, 1, 8'h55, 0, 0); expect_grant("R8 app space", 8'h55);
    step(1, 0, 1, 8'hFF, 0, 0); expect_grant("R8 top value", 8'hFF);
  endtask

  task automatic t_reserved();
    step(1, 0, 1, 8'h00, 0, 0); expect_fault("R9 reserved 0x00");
    step(1, 0, 1, 8'h07, 0, 0); expect_fault("R9 reserved 0x07");
    step(1, 0, 1, 8'h08, 0, 0); expect_grant("R9 edge 0x08", 8'h08);
  endtask

  task automatic t_to_user();
    step(0, 0, 0, 0, 0, 1);
    step(1, 1, 0, 0, 0, 0); expect_grant("R6 rett to user fetch", 8'h08);
    step(1, 0, 0, 0, 0, 0); expect_grant("R4 user data", 8'h0A);
  endtask

  task automatic t_user_named();
    step(1, 0, 1, 8'h0A, 0, 0); expect_fault("R7 user names user data");
    step(1, 1, 1, 8'h40, 0, 0); expect_fault("R7 user names app space");
    step(1, 0, 1, 8'h03, 0, 0); expect_fault("R7 user names reserved");
  endtask

  task automatic t_trap_cycle();
    // user mode here; request rides with the trap
    step(1, 1, 0, 0, 1, 0); expect_grant("R10 request with trap", 8'h08);
    step(1, 1, 0, 0, 0, 0); expect_grant("R5 trap to supervisor", 8'h09);
    // request rides with the rett, still supervisor
    step(1, 0, 0, 0, 0, 1); expect_grant("R10 request with rett", 8'h0B);
    step(1, 1, 0, 0, 0, 0); expect_grant("R6 rett restores user", 8'h08);
  endtask

  task automatic t_trap_wins();
    step(0, 0, 0, 0, 1, 1);
    step(1, 1, 0, 0, 0, 0); expect_grant("R5 trap beats rett", 8'h09);
    step(0, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 0); expect_grant("R5 saved user on trap", 8'h0A);
    // trap from supervisor saves supervisor
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    step(1, 1, 0, 0, 0, 0); expect_grant("R5 nested save is supervisor", 8'h09);
  endtask

  initial begin
    idle_inputs();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_sup_plain();
    t_idle();
    t_sup_named();
    t_reserved();
    t_to_user();
    t_user_named();
    t_trap_cycle();
    t_trap_wins();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule